// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

The block is a two-plane programmable logic array. An AND plane forms each product term from any mix of the primary inputs, taken either true or inverted, and an OR plane gathers any subset of those terms into each output. One product term can feed several outputs, so a term used by more than one function is built once. Input-to-output evaluation is purely combinational. The configuration registers only hold the personality that shapes that evaluation.

The personality is held as one row per product term. Each row is loaded through a synchronous write port, one row per write, and any row can be read back combinationally. A reset clears the whole personality, so every output stays low until the array is programmed.

Top module: `sop_array`

## Requirements
- R1: Each AND-plane cell is 2 bits. 2'b01 makes the term require the input high, 2'b10 makes it require the input low, and 2'b00 leaves the input out of the term.
- R2: The cell code 2'b11 is reserved and forces its product term to 0 whatever the inputs are.
- R3: A term whose cells are all 2'b00 is constantly 1. It raises only the outputs whose OR-plane bit is set in its row.
- R4: OR-plane bit j of a row connects that term to output j. Output j is the OR of every connected term, and one term may drive several outputs.
- R5: An output with no connected term is 0.
- R6: With cfg_we_i high, cfg_data_i is stored into row cfg_row_i at the rising clock edge. Before that edge the row and the outputs keep their old values.
- R7: A write to a row index at or above the term count changes no row. Reading back such an index returns 0.
- R8: rd_data_o shows, combinationally, the stored row selected by rd_row_i.
- R9: The asynchronous active-low reset clears every row, so all outputs and all readback values are 0.
- R10: Load the personality AB, B'C, AC', B'C', A, with inputs A, B and C on in_i[2], in_i[1] and in_i[0]. The outputs out_o[0..3] must then equal A+B'C', AC'+AB, B'C'+AB and B'C+A for all 8 input patterns.

Row layout: bits [N_OUT-1:0] hold the OR-plane bits, where bit j is output j. Bits [N_OUT+2i+1 : N_OUT+2i] hold the AND cell for in_i[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Row write enable |
| cfg_row_i | input | IDX_W | Product-term row to write |
| cfg_data_i | input | 2*N_IN+N_OUT | Row contents: AND cells above, OR bits below |
| rd_row_i | input | IDX_W | Row selected for readback |
| rd_data_o | output | 2*N_IN+N_OUT | Stored contents of the selected row |
| in_i | input | N_IN | Primary inputs |
| out_o | output | N_OUT | Sum-of-products outputs |

## Verification
The cases hardest to reach from the ports are the reserved cell code and a term left with no participating input. Neither occurs in the reference personality, so the bench rewrites the term that stands for A after the reference load. It then picks input patterns where a mishandled code would visibly set or clear outputs that share other terms. Indices above the term count are reached only through deliberate out-of-range writes and reads. For these, the bench checks both the aliased in-range row and the unchanged outputs.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    CELL_SKIP = 2'b00,
    CELL_TRUE = 2'b01,
    CELL_INV  = 2'b10,
    CELL_BAD  = 2'b11
  } cell_e;

  function automatic logic cell_pass(input cell_e c, input logic x);
    unique case (c)
      CELL_SKIP: return 1'b1;
      CELL_TRUE: return x;
      CELL_INV:  return ~x;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int N_TERM = 5,
  parameter int ROW_W  = 10,
  parameter int IDX_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              row_i,
  input  logic [ROW_W-1:0]              data_i,
  input  logic [IDX_W-1:0]              rd_row_i,
  output logic [ROW_W-1:0]              rd_data_o,
  output logic [N_TERM-1:0][ROW_W-1:0]  rows_o
);
  logic [N_TERM-1:0][ROW_W-1:0] rows_q;

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            rows_q[t] <= '0;
      else if (we_i && row_i == IDX_W'(t))    rows_q[t] <= data_i;
    end
  end

  // indices past the last term read as zero
  always_comb begin
    rd_data_o = '0;
    for (int t = 0; t < N_TERM; t++) begin
      if (rd_row_i == IDX_W'(t)) rd_data_o = rows_q[t];
    end
  end

  assign rows_o = rows_q;
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic [N_IN-1:0]                  in_i,
  input  logic [N_TERM-1:0][2*N_IN-1:0]    cells_i,
  output logic [N_TERM-1:0]                term_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    always_comb begin
      term_o[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        term_o[t] = term_o[t] & cell_pass(cell_e'(cells_i[t][2*i +: 2]), in_i[i]);
      end
    end
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic [N_TERM-1:0]              term_i,
  input  logic [N_TERM-1:0][N_OUT-1:0]   conn_i,
  output logic [N_OUT-1:0]               out_o
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    always_comb begin
      out_o[j] = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        out_o[j] = out_o[j] | (term_i[t] & conn_i[t][j]);
      end
    end
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 5,
  localparam int ROW_W = 2*N_IN + N_OUT,
  localparam int IDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_row_i,
  input  logic [ROW_W-1:0]  cfg_data_i,
  input  logic [IDX_W-1:0]  rd_row_i,
  output logic [ROW_W-1:0]  rd_data_o,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  out_o
);
  logic [N_TERM-1:0][ROW_W-1:0]   rows_w;
  logic [N_TERM-1:0][2*N_IN-1:0]  cells_w;
  logic [N_TERM-1:0][N_OUT-1:0]   conn_w;
  logic [N_TERM-1:0]              term_w;

  sop_cfg_store #(.N_TERM(N_TERM), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .row_i     (cfg_row_i),
    .data_i    (cfg_data_i),
    .rd_row_i  (rd_row_i),
    .rd_data_o (rd_data_o),
    .rows_o    (rows_w)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_split
    assign cells_w[t] = rows_w[t][ROW_W-1:N_OUT];
    assign conn_w[t]  = rows_w[t][N_OUT-1:0];
  end

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_i    (in_i),
    .cells_i (cells_w),
    .term_o  (term_w)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i (term_w),
    .conn_i (conn_w),
    .out_o  (out_o)
  );
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 5,
  parameter int ROW_W  = 10,
  parameter int IDX_W  = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cfg_we_i,
  input logic [IDX_W-1:0]              cfg_row_i,
  input logic [ROW_W-1:0]              cfg_data_i,
  input logic [IDX_W-1:0]              rd_row_i,
  input logic [ROW_W-1:0]              rd_data_o,
  input logic [N_OUT-1:0]              out_o,
  input logic [N_TERM-1:0][ROW_W-1:0]  rows_i,
  input logic [N_TERM-1:0]             terms_i
);
  localparam logic [IDX_W:0] TERM_LIM = (IDX_W+1)'(N_TERM);

  logic wr_oob, rd_oob;
  assign wr_oob = {1'b0, cfg_row_i} >= TERM_LIM;
  assign rd_oob = {1'b0, rd_row_i} >= TERM_LIM;

  logic             wr_vld_q, first_q;
  logic [IDX_W-1:0] wr_row_q;
  logic [ROW_W-1:0] wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_q  <= 1'b0;
      wr_row_q  <= '0;
      wr_data_q <= '0;
      first_q   <= 1'b1;
    end else begin
      wr_vld_q  <= cfg_we_i && !wr_oob;
      wr_row_q  <= cfg_row_i;
      wr_data_q <= cfg_data_i;
      first_q   <= 1'b0;
    end
  end

  assert_write_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_q |-> rows_i[wr_row_q] == wr_data_q);

  assert_oob_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_oob) |=> $stable(rows_i));

  assert_oob_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oob |-> rd_data_o == '0);

  assert_reset_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (rows_i == '0 && out_o == '0));

  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    logic bad;
    always_comb begin
      bad = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (rows_i[t][N_OUT+2*i +: 2] == 2'b11) bad = 1'b1;
      end
    end
    assert_reserved_kills_term_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad |-> !terms_i[t]);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
    logic any_conn;
    always_comb begin
      any_conn = 1'b0;
      for (int t = 0; t < N_TERM; t++) any_conn = any_conn | rows_i[t][j];
    end
    assert_unconnected_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_conn |-> !out_o[j]);
  end
endmodule

bind sop_array sop_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .ROW_W(ROW_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_row_i  (cfg_row_i),
  .cfg_data_i (cfg_data_i),
  .rd_row_i   (rd_row_i),
  .rd_data_o  (rd_data_o),
  .out_o      (out_o),
  .rows_i     (rows_w),
  .terms_i    (term_w)
);

// File: tb/sop_array_tb.sv
module sop_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 3, N_OUT = 4, N_TERM = 5;
  localparam int ROW_W = 2*N_IN + N_OUT;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [IDX_W-1:0] cfg_row_i = '0;
  logic [ROW_W-1:0] cfg_data_i = '0;
  logic [IDX_W-1:0] rd_row_i = '0;
  logic [ROW_W-1:0] rd_data_o;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_OUT-1:0] out_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_row_i(cfg_row_i),
    .cfg_data_i(cfg_data_i), .rd_row_i(rd_row_i), .rd_data_o(rd_data_o),
    .in_i(in_i), .out_o(out_o)
  );

  typedef struct {
    bit               is_rd;
    logic [2:0]       sel;
    logic [ROW_W-1:0] exp;
    string            req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // row = {A cell, B cell, C cell, OR bits F3..F0}
  function automatic logic [ROW_W-1:0] mk(logic [1:0] a, logic [1:0] b, logic [1:0] c,
                                          logic [3:0] o);
    return {a, b, c, o};
  endfunction

  function automatic logic [3:0] ref_eq(logic [2:0] p);
    logic a, b, c;
    a = p[2]; b = p[1]; c = p[0];
    return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
  endfunction

  task automatic compare(string req, logic [ROW_W-1:0] act, logic [ROW_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_out(logic [2:0] p, logic [3:0] exp, string req);
    item_t it;
    @(negedge clk);
    in_i = p;
    it.is_rd = 1'b0; it.sel = p; it.exp = ROW_W'(exp); it.req = req;
    q.push_back(it);
  endtask

  task automatic chk_rd(logic [2:0] r, logic [ROW_W-1:0] exp, string req);
    item_t it;
    @(negedge clk);
    rd_row_i = r;
    it.is_rd = 1'b1; it.sel = r; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [2:0] r, logic [ROW_W-1:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_row_i = r; cfg_data_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // monitor: sample a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.is_rd) compare(it.req, rd_data_o, it.exp);
        else          compare(it.req, ROW_W'(out_o), it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 / R5: cleared personality, all-don't-care terms unconnected
    chk_out(3'b111, 4'b0000, "R9 R5 reset outputs");
    chk_rd(3'd0, '0, "R9 reset row");
    @(negedge clk);
    rst_ni = 1'b1;
    chk_out(3'b000, 4'b0000, "R5 R3 unconnected after reset");
    chk_rd(3'd4, '0, "R9 row4 after reset");

    // R6: row not visible before the edge, visible after
    @(negedge clk);
    rd_row_i = 3'd0;
    cfg_we_i = 1'b1; cfg_row_i = 3'd0; cfg_data_i = mk(2'b01, 2'b01, 2'b00, 4'b0110);
    #1 compare("R6 before edge", rd_data_o, '0);
    @(negedge clk);
    cfg_we_i = 1'b0;
    chk_rd(3'd0, mk(2'b01, 2'b01, 2'b00, 4'b0110), "R6 R8 after edge");

    wr(3'd1, mk(2'b00, 2'b10, 2'b01, 4'b1000));
    wr(3'd2, mk(2'b01, 2'b00, 2'b10, 4'b0010));
    wr(3'd3, mk(2'b00, 2'b10, 2'b10, 4'b0101));
    wr(3'd4, mk(2'b01, 2'b00, 2'b00, 4'b1001));
    chk_rd(3'd3, mk(2'b00, 2'b10, 2'b10, 4'b0101), "R8 row3");
    chk_rd(3'd1, mk(2'b00, 2'b10, 2'b01, 4'b1000), "R8 row1");

    for (int p = 0; p < 8; p++)
      chk_out(3'(p), ref_eq(3'(p)), "R10 R1 R4 reference equations");

    // R7: out-of-range write ignored, reads as zero, no aliasing
    wr(3'd5, mk(2'b10, 2'b10, 2'b01, 4'b0111));
    chk_rd(3'd5, '0, "R7 oob read");
    chk_rd(3'd7, '0, "R7 oob read 7");
    chk_rd(3'd1, mk(2'b00, 2'b10, 2'b01, 4'b1000), "R7 no alias row1");
    chk_out(3'b001, ref_eq(3'b001), "R7 outputs unchanged");

    // R2: reserved code on the A term
    wr(3'd4, mk(2'b11, 2'b00, 2'b00, 4'b1001));
    chk_out(3'b111, 4'b0110, "R2 reserved cell 111");
    chk_out(3'b100, 4'b0111, "R2 reserved cell 100");

    // R3: constant term feeding only F3
    wr(3'd4, mk(2'b00, 2'b00, 2'b00, 4'b1000));
    chk_out(3'b000, 4'b1101, "R3 constant term 000");
    chk_out(3'b110, 4'b1110, "R3 constant term 110");

    // R5: drop every connection to F3
    wr(3'd4, mk(2'b00, 2'b00, 2'b00, 4'b0000));
    wr(3'd1, mk(2'b00, 2'b10, 2'b01, 4'b0000));
    chk_out(3'b001, 4'b0000, "R5 F3 unconnected 001");
    chk_out(3'b100, 4'b0111, "R5 F3 unconnected 100");

    // R9: reset in mid run
    @(negedge clk);
    rst_ni = 1'b0;
    chk_out(3'b111, 4'b0000, "R9 mid-run reset outputs");
    chk_rd(3'd2, '0, "R9 mid-run reset row2");
    @(negedge clk);
    rst_ni = 1'b1;

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule